// File: doc/BRIEF.md
# Checkable Multiply/Divide Stand-in Unit

This unit executes the 32-bit-word multiply, divide and modulo instructions of a 64-bit POWER-style integer core, but in a proof-friendly substitute mode. It does not form real products or quotients. Each opcode instead produces a plain 64-bit sum (multiply class) or difference (divide and modulo classes) of its two shaped operands, scrambled by an XOR with a fixed 64-bit constant chosen per opcode. A formal harness can predict this cheaply while every decode path, operand-shaping rule, flag update and condition-field update stays exercised exactly as the real unit would exercise it.

One instruction is accepted in any cycle where `in_valid` is high, together with the two source register values, the current instruction address, the 64-bit-mode flag and the incoming summary-overflow bit. One cycle later the registered result appears with `out_valid`: destination index and data, overflow-flag updates, an optional condition-field-0 update and the next instruction address. An instruction word outside the supported set raises `illegal` and writes nothing.

Top module: `mdsub_unit`

## Requirements
- R1: Word bits are numbered with bit 31 as the MSB: primary opcode insn[31:26], RT insn[25:21], OE insn[10], 9-bit extended opcode insn[9:1], 10-bit extended opcode insn[10:1], Rc insn[0], immediate insn[15:0]. Legal words are: primary 7 (multiply-immediate); primary 31 with 9-bit code 235 (multiply-low), 75 (multiply-high signed), 11 (multiply-high unsigned), 491 (divide signed), 459 (divide unsigned), 427 (divide-extended signed), 395 (divide-extended unsigned); primary 31 with 10-bit code 779 (modulo signed) or 267 (modulo unsigned) and insn[0]=0. Multiply-high words with OE=1 and any other word are illegal: `illegal` is set and all four write enables stay low.
- R2: Operand A is the full 64-bit RA for multiply-immediate; the sign-extended low word of RA for multiply-low, multiply-high signed, divide signed and modulo signed; the zero-extended low word for multiply-high unsigned, divide unsigned and modulo unsigned; and the low word of RA shifted into bits 63:32 with zeros below for both divide-extended forms.
- R3: Operand B is the sign-extended 16-bit immediate for multiply-immediate; otherwise the low word of RB, sign-extended for multiply-low, multiply-high signed, divide signed, divide-extended signed and modulo signed, and zero-extended for the unsigned forms.
- R4: The written data is (A+B) XOR K for the multiply class and (A-B) XOR K (64-bit) for divide and modulo, where K is: multiply-immediate ef31a883837039a0; multiply-low 4931591f31f56de1 (OE=1: 37291ea821fbaf9d); multiply-high signed 3426dcf55920989c; multiply-high unsigned 491edb8a5f695d49; divide signed 75a5d4895a3e15ba (OE=1: 7098f59fd4822d48); divide unsigned 769c76af68d11402 (OE=1: 6ec48c33b1fe6a8f); divide-extended signed dfd9d577965d84d2 (OE=1: 88ec39a41f3b07fd); divide-extended unsigned 8fc71f88b966fcf0 (OE=1: 893cca367133b0d3); modulo signed 5ba1758b11ae4e43; modulo unsigned 1feb9d95f9f0cea5 (all hex).
- R5: For OE=1 words, with S the raw sum or difference, c = S[32]^A[32]^B[32] and V = (c^S[31]) & ~(A[31]^B[31]); `ov_we` is high and both `ov_val` and `ov32_val` equal V; `so_we` (set SO to 1) is high only when V is 1.
- R6: Words with OE=0, multiply-high, modulo and multiply-immediate leave `ov_we` and `so_we` low, whatever their operands.
- R7: For Rc=1 words `cr0_we` is high and `cr0_val` = {LT, GT, EQ, SO} (bit 3 to bit 0), with exactly one of LT, GT, EQ set; GT is set when neither LT nor EQ is.
- R8: The SO bit of `cr0_val` is 1 when this instruction sets SO, otherwise it copies `so_in`.
- R9: With `mode64`=1, LT is data bit 63 and EQ means all 64 data bits are zero; with `mode64`=0, LT is bit 31 and EQ means data bits 31:0 are zero.
- R10: `nia` is `cia`+4 when `mode64`=1, and the low 32 bits of `cia`+4 with bits 63:32 zero when `mode64`=0.
- R11: All outputs are registered: `out_valid` follows `in_valid` one clock later, and with `out_valid` low no write enable and no `illegal` is raised.
- R12: Synchronous active-high `rst` clears `out_valid`, `illegal` and all write enables.
- R13: For a legal word `rt_we` is high and `rt_idx` equals insn[25:21].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present this cycle |
| insn | input | 32 | Instruction word |
| ra_val | input | 64 | First source register value |
| rb_val | input | 64 | Second source register value (low word used) |
| cia | input | 64 | Current instruction address |
| mode64 | input | 1 | 64-bit mode flag |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Registered result valid |
| illegal | output | 1 | Word not in the supported set |
| rt_we | output | 1 | Destination write enable |
| rt_idx | output | 5 | Destination register index |
| rt_data | output | 64 | Destination data |
| ov_we | output | 1 | Write OV and OV32 |
| ov_val | output | 1 | New OV value |
| ov32_val | output | 1 | New OV32 value |
| so_we | output | 1 | Set SO to 1 |
| cr0_we | output | 1 | Write condition field 0 |
| cr0_val | output | 4 | {LT, GT, EQ, SO} |
| nia | output | 64 | Next instruction address |

## Verification
The hardest situation to reach is an overflow that sets SO and then has to show up in the condition field of the same instruction, because the overflow rule only fires for additions whose operands share bit 31 and subtractions never satisfy it. The stimulus therefore uses recording multiply-low words with operands at the signed word limits (0x7fffffff+1 and 0x80000000+0x80000000) with `so_in` low, so a set SO bit in `cr0_val` can only come from the new overflow. A zero result is equally indirect since the mask is applied after the sum; operands equal to the low word of the multiply-low constant make the low 32 result bits zero, and the same word in both modes separates EQ from GT.

// File: rtl/mdsub_pkg.sv
package mdsub_pkg;

    localparam int XLEN = 64;
    localparam int WLEN = 32;
    localparam int IMMW = 16;
    localparam int RIDX = 5;
    localparam int CRW  = 4;

    localparam logic [5:0] PO_MUL_IMM = 6'd7;
    localparam logic [5:0] PO_EXT     = 6'd31;

    localparam logic [8:0] XO_MUL_LO   = 9'd235;
    localparam logic [8:0] XO_MUL_HI_S = 9'd75;
    localparam logic [8:0] XO_MUL_HI_U = 9'd11;
    localparam logic [8:0] XO_DIV_S    = 9'd491;
    localparam logic [8:0] XO_DIV_U    = 9'd459;
    localparam logic [8:0] XO_DIVX_S   = 9'd427;
    localparam logic [8:0] XO_DIVX_U   = 9'd395;
    localparam logic [9:0] XO10_MOD_S  = 10'd779;
    localparam logic [9:0] XO10_MOD_U  = 10'd267;

    typedef enum logic [3:0] {
        K_NONE, K_MUL_IMM, K_MUL_LO, K_MUL_HI_S, K_MUL_HI_U,
        K_DIV_S, K_DIV_U, K_DIVX_S, K_DIVX_U, K_MOD_S, K_MOD_U
    } kind_e;

    typedef enum logic [1:0] { A_FULL, A_SEXT, A_ZEXT, A_HIGH } asel_e;
    typedef enum logic [1:0] { B_IMM, B_SEXT, B_ZEXT } bsel_e;

    typedef struct packed {
        logic             legal;
        kind_e            kind;
        asel_e            a_sel;
        bsel_e            b_sel;
        logic             sub;
        logic             oe;
        logic             rc;
        logic [RIDX-1:0]  rt;
        logic [IMMW-1:0]  imm;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] data;
        logic            ov;
        logic            so_set;
        logic [CRW-1:0]  cr0;
    } alu_t;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic            rt_we;
        logic [RIDX-1:0] rt_idx;
        logic [XLEN-1:0] data;
        logic            ov_we;
        logic            ov;
        logic            so_we;
        logic            cr0_we;
        logic [CRW-1:0]  cr0;
        logic [XLEN-1:0] nia;
    } out_t;

    function automatic logic [XLEN-1:0] mask_for(kind_e k, logic oe);
        case (k)
            K_MUL_IMM:  return 64'hef31a883837039a0;
            K_MUL_LO:   return oe ? 64'h37291ea821fbaf9d : 64'h4931591f31f56de1;
            K_MUL_HI_S: return 64'h3426dcf55920989c;
            K_MUL_HI_U: return 64'h491edb8a5f695d49;
            K_DIV_S:    return oe ? 64'h7098f59fd4822d48 : 64'h75a5d4895a3e15ba;
            K_DIV_U:    return oe ? 64'h6ec48c33b1fe6a8f : 64'h769c76af68d11402;
            K_DIVX_S:   return oe ? 64'h88ec39a41f3b07fd : 64'hdfd9d577965d84d2;
            K_DIVX_U:   return oe ? 64'h893cca367133b0d3 : 64'h8fc71f88b966fcf0;
            K_MOD_S:    return 64'h5ba1758b11ae4e43;
            K_MOD_U:    return 64'h1feb9d95f9f0cea5;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/mdsub_decode.sv
module mdsub_decode
    import mdsub_pkg::*;
(
    input  logic [WLEN-1:0] insn,
    output dec_t            dec
);
    logic [5:0] po;
    logic [8:0] xo9;
    logic [9:0] xo10;
    logic       oe_bit;
    logic       rc_bit;
    logic       unused_src_field;

    assign po     = insn[31:26];
    assign xo9    = insn[9:1];
    assign xo10   = insn[10:1];
    assign oe_bit = insn[10];
    assign rc_bit = insn[0];
    assign unused_src_field = ^insn[20:16];

    always_comb begin
        dec     = '0;
        dec.rt  = insn[25:21];
        dec.imm = insn[15:0];
        if (po == PO_MUL_IMM) begin
            dec.legal = 1'b1;
            dec.kind  = K_MUL_IMM;
            dec.a_sel = A_FULL;
            dec.b_sel = B_IMM;
        end else if (po == PO_EXT) begin
            if (!rc_bit && xo10 == XO10_MOD_S) begin
                dec.legal = 1'b1;
                dec.kind  = K_MOD_S;
                dec.a_sel = A_SEXT;
                dec.b_sel = B_SEXT;
                dec.sub   = 1'b1;
            end else if (!rc_bit && xo10 == XO10_MOD_U) begin
                dec.legal = 1'b1;
                dec.kind  = K_MOD_U;
                dec.a_sel = A_ZEXT;
                dec.b_sel = B_ZEXT;
                dec.sub   = 1'b1;
            end else begin
                dec.oe = oe_bit;
                dec.rc = rc_bit;
                case (xo9)
                    XO_MUL_LO: begin
                        dec.legal = 1'b1; dec.kind = K_MUL_LO;
                        dec.a_sel = A_SEXT; dec.b_sel = B_SEXT;
                    end
                    XO_MUL_HI_S: begin
                        dec.legal = !oe_bit; dec.kind = K_MUL_HI_S;
                        dec.a_sel = A_SEXT; dec.b_sel = B_SEXT;
                    end
                    XO_MUL_HI_U: begin
                        dec.legal = !oe_bit; dec.kind = K_MUL_HI_U;
                        dec.a_sel = A_ZEXT; dec.b_sel = B_ZEXT;
                    end
                    XO_DIV_S: begin
                        dec.legal = 1'b1; dec.kind = K_DIV_S; dec.sub = 1'b1;
                        dec.a_sel = A_SEXT; dec.b_sel = B_SEXT;
                    end
                    XO_DIV_U: begin
                        dec.legal = 1'b1; dec.kind = K_DIV_U; dec.sub = 1'b1;
                        dec.a_sel = A_ZEXT; dec.b_sel = B_ZEXT;
                    end
                    XO_DIVX_S: begin
                        dec.legal = 1'b1; dec.kind = K_DIVX_S; dec.sub = 1'b1;
                        dec.a_sel = A_HIGH; dec.b_sel = B_SEXT;
                    end
                    XO_DIVX_U: begin
                        dec.legal = 1'b1; dec.kind = K_DIVX_U; dec.sub = 1'b1;
                        dec.a_sel = A_HIGH; dec.b_sel = B_ZEXT;
                    end
                    default: dec.legal = 1'b0;
                endcase
                if (!dec.legal) begin
                    dec.oe   = 1'b0;
                    dec.rc   = 1'b0;
                    dec.kind = K_NONE;
                end
            end
        end
    end
endmodule

// File: rtl/mdsub_operands.sv
module mdsub_operands
    import mdsub_pkg::*;
(
    input  asel_e           a_sel,
    input  bsel_e           b_sel,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] ra,
    input  logic [XLEN-1:0] rb,
    output logic [XLEN-1:0] opa,
    output logic [XLEN-1:0] opb
);
    localparam int HI = XLEN - WLEN;

    logic [WLEN-1:0] ra_lo;
    logic [WLEN-1:0] rb_lo;
    logic            unused_rb_high;

    assign ra_lo = ra[WLEN-1:0];
    assign rb_lo = rb[WLEN-1:0];
    assign unused_rb_high = ^rb[XLEN-1:WLEN];

    always_comb begin
        case (a_sel)
            A_FULL:  opa = ra;
            A_SEXT:  opa = {{HI{ra_lo[WLEN-1]}}, ra_lo};
            A_ZEXT:  opa = {{HI{1'b0}}, ra_lo};
            default: opa = {ra_lo, {HI{1'b0}}};
        endcase
        case (b_sel)
            B_IMM:   opb = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
            B_SEXT:  opb = {{HI{rb_lo[WLEN-1]}}, rb_lo};
            default: opb = {{HI{1'b0}}, rb_lo};
        endcase
    end
endmodule

// File: rtl/mdsub_alu.sv
module mdsub_alu
    import mdsub_pkg::*;
(
    input  kind_e           kind,
    input  logic            oe,
    input  logic            sub,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            mode64,
    input  logic            so_in,
    output alu_t            res
);
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] scr;
    logic            c32;
    logic            ovf;
    logic            lt;
    logic            eq;

    always_comb begin
        raw = sub ? (opa - opb) : (opa + opb);
        scr = raw ^ mask_for(kind, oe);
        c32 = raw[WLEN] ^ opa[WLEN] ^ opb[WLEN];
        ovf = (c32 ^ raw[WLEN-1]) & ~(opa[WLEN-1] ^ opb[WLEN-1]);
        lt  = mode64 ? scr[XLEN-1] : scr[WLEN-1];
        eq  = mode64 ? (scr == '0) : (scr[WLEN-1:0] == '0);

        res.data   = scr;
        res.ov     = ovf;
        res.so_set = oe & ovf;
        res.cr0    = {lt, ~(lt | eq), eq, (oe & ovf) | so_in};
    end
endmodule

// File: rtl/mdsub_unit.sv
module mdsub_unit
    import mdsub_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [63:0]     ra_val,
    input  logic [63:0]     rb_val,
    input  logic [63:0]     cia,
    input  logic            mode64,
    input  logic            so_in,
    output logic            out_valid,
    output logic            illegal,
    output logic            rt_we,
    output logic [4:0]      rt_idx,
    output logic [63:0]     rt_data,
    output logic            ov_we,
    output logic            ov_val,
    output logic            ov32_val,
    output logic            so_we,
    output logic            cr0_we,
    output logic [3:0]      cr0_val,
    output logic [63:0]     nia
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    dec_t            dec;
    alu_t            alu;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] nia_full;
    logic [XLEN-1:0] nia_d;
    logic            go;
    out_t            q;

    mdsub_decode u_dec (
        .insn (insn),
        .dec  (dec)
    );

    mdsub_operands u_ops (
        .a_sel (dec.a_sel),
        .b_sel (dec.b_sel),
        .imm   (dec.imm),
        .ra    (ra_val),
        .rb    (rb_val),
        .opa   (opa),
        .opb   (opb)
    );

    mdsub_alu u_alu (
        .kind   (dec.kind),
        .oe     (dec.oe),
        .sub    (dec.sub),
        .opa    (opa),
        .opb    (opb),
        .mode64 (mode64),
        .so_in  (so_in),
        .res    (alu)
    );

    assign nia_full = cia + STEP;
    assign nia_d    = mode64 ? nia_full : {{(XLEN-WLEN){1'b0}}, nia_full[WLEN-1:0]};
    assign go       = in_valid & dec.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid   <= in_valid;
            q.illegal <= in_valid & ~dec.legal;
            q.rt_we   <= go;
            q.rt_idx  <= dec.rt;
            q.data    <= alu.data;
            q.ov_we   <= go & dec.oe;
            q.ov      <= alu.ov;
            q.so_we   <= go & alu.so_set;
            q.cr0_we  <= go & dec.rc;
            q.cr0     <= alu.cr0;
            q.nia     <= nia_d;
        end
    end

    assign out_valid = q.valid;
    assign illegal   = q.illegal;
    assign rt_we     = q.rt_we;
    assign rt_idx    = q.rt_idx;
    assign rt_data   = q.data;
    assign ov_we     = q.ov_we;
    assign ov_val    = q.ov;
    assign ov32_val  = q.ov;
    assign so_we     = q.so_we;
    assign cr0_we    = q.cr0_we;
    assign cr0_val   = q.cr0;
    assign nia       = q.nia;
endmodule

// File: rtl/mdsub_unit_chk.sv
module mdsub_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] insn,
    input logic [63:0] ra_val,
    input logic [63:0] rb_val,
    input logic [63:0] cia,
    input logic        mode64,
    input logic        so_in,
    input logic        out_valid,
    input logic        illegal,
    input logic        rt_we,
    input logic [4:0]  rt_idx,
    input logic [63:0] rt_data,
    input logic        ov_we,
    input logic        ov_val,
    input logic        ov32_val,
    input logic        so_we,
    input logic        cr0_we,
    input logic [3:0]  cr0_val,
    input logic [63:0] nia
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(rt_we || ov_we || so_we || cr0_we || illegal));

    a_r1_illegal_mutes: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(rt_we || ov_we || so_we || cr0_we));

    a_r13_legal_writes: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal) |-> (rt_we && rt_idx == $past(insn[25:21])));

    a_r5_so_needs_ov: assert property (@(posedge clk) disable iff (rst)
        so_we |-> (ov_we && ov_val && ov32_val));

    a_r5_ov_sets_so: assert property (@(posedge clk) disable iff (rst)
        (ov_we && ov_val) |-> so_we);

    a_r7_cr0_single: assert property (@(posedge clk) disable iff (rst)
        cr0_we |-> ($countones(cr0_val[3:1]) == 1));

    a_r8_cr0_so_new: assert property (@(posedge clk) disable iff (rst)
        (cr0_we && so_we) |-> cr0_val[0]);

    a_r10_next_addr: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (nia == ($past(mode64) ? ($past(cia) + 64'd4)
                                             : {32'd0, $past(cia[31:0]) + 32'd4})));
endmodule

bind mdsub_unit mdsub_unit_chk u_chk (.*);

// File: tb/mdsub_unit_test.sv
`timescale 1ns/1ps
module mdsub_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] insn;
    logic [63:0] ra_val, rb_val, cia;
    logic        mode64, so_in;
    logic        out_valid, illegal, rt_we, ov_we, ov_val, ov32_val, so_we, cr0_we;
    logic [4:0]  rt_idx;
    logic [63:0] rt_data, nia;
    logic [3:0]  cr0_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdsub_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .ra_val(ra_val), .rb_val(rb_val), .cia(cia), .mode64(mode64), .so_in(so_in),
        .out_valid(out_valid), .illegal(illegal), .rt_we(rt_we), .rt_idx(rt_idx),
        .rt_data(rt_data), .ov_we(ov_we), .ov_val(ov_val), .ov32_val(ov32_val),
        .so_we(so_we), .cr0_we(cr0_we), .cr0_val(cr0_val), .nia(nia)
    );

    function automatic logic [31:0] f_xo(input logic [4:0] rt, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic oe,
                                         input logic [8:0] xo, input logic rc);
        return {6'd31, rt, ra, rb, oe, xo, rc};
    endfunction

    function automatic logic [31:0] f_x(input logic [4:0] rt, input logic [4:0] ra,
                                        input logic [4:0] rb, input logic [9:0] xo,
                                        input logic b0);
        return {6'd31, rt, ra, rb, xo, b0};
    endfunction

    function automatic logic [31:0] f_im(input logic [4:0] rt, input logic [4:0] ra,
                                         input logic [15:0] si);
        return {6'd7, rt, ra, si};
    endfunction

    // {insn, ra, rb, mode64, so_in, expected illegal}
    typedef logic [162:0] vec_t;
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        {f_im(5'd3, 5'd4, 16'h8001),              64'h0123456789abcdef, 64'h0,                 1'b1, 1'b0, 1'b0},
        {f_xo(5'd1, 5'd2, 5'd3, 1'b0, 9'd235, 1'b0), 64'hffffffff7fffffff, 64'h1,               1'b1, 1'b0, 1'b0},
        {f_xo(5'd2, 5'd2, 5'd3, 1'b1, 9'd235, 1'b0), 64'h000000007fffffff, 64'h1,               1'b1, 1'b0, 1'b0},
        {f_xo(5'd4, 5'd5, 5'd6, 1'b1, 9'd235, 1'b1), 64'h0000000080000000, 64'h0000000080000000, 1'b0, 1'b0, 1'b0},
        {f_xo(5'd7, 5'd8, 5'd9, 1'b0, 9'd235, 1'b1), 64'h0000000031f56de1, 64'h0,               1'b0, 1'b0, 1'b0},
        {f_xo(5'd7, 5'd8, 5'd9, 1'b0, 9'd235, 1'b1), 64'h0000000031f56de1, 64'h0,               1'b1, 1'b0, 1'b0},
        {f_xo(5'd10, 5'd1, 5'd2, 1'b0, 9'd75, 1'b1), 64'h1234567887654321, 64'h00000000deadbeef, 1'b1, 1'b1, 1'b0},
        {f_xo(5'd11, 5'd1, 5'd2, 1'b0, 9'd11, 1'b0), 64'hffffffffffffffff, 64'hffffffffffffffff, 1'b0, 1'b0, 1'b0},
        {f_xo(5'd12, 5'd1, 5'd2, 1'b0, 9'd491, 1'b0), 64'h10,               64'h3,               1'b1, 1'b0, 1'b0},
        {f_xo(5'd13, 5'd1, 5'd2, 1'b1, 9'd491, 1'b1), 64'h0000000080000000, 64'h1,               1'b0, 1'b1, 1'b0},
        {f_xo(5'd14, 5'd1, 5'd2, 1'b0, 9'd459, 1'b0), 64'h0,                64'h1,               1'b1, 1'b0, 1'b0},
        {f_xo(5'd15, 5'd1, 5'd2, 1'b1, 9'd459, 1'b0), 64'h00000000ffffffff, 64'h0000000080000000, 1'b1, 1'b0, 1'b0},
        {f_xo(5'd16, 5'd1, 5'd2, 1'b0, 9'd427, 1'b0), 64'h000000000000abcd, 64'h00000000ffff0000, 1'b1, 1'b0, 1'b0},
        {f_xo(5'd17, 5'd1, 5'd2, 1'b1, 9'd427, 1'b1), 64'h1,                64'h000000007fffffff, 1'b0, 1'b0, 1'b0},
        {f_xo(5'd18, 5'd1, 5'd2, 1'b0, 9'd395, 1'b1), 64'h1234,             64'h9,               1'b1, 1'b0, 1'b0},
        {f_xo(5'd19, 5'd1, 5'd2, 1'b1, 9'd395, 1'b0), 64'h00000000ffffffff, 64'h00000000ffffffff, 1'b1, 1'b0, 1'b0},
        {f_x(5'd20, 5'd1, 5'd2, 10'd779, 1'b0),     64'hfffffffffffffffb, 64'h7,               1'b1, 1'b0, 1'b0},
        {f_x(5'd21, 5'd1, 5'd2, 10'd267, 1'b0),     64'h5,                64'h5,               1'b0, 1'b0, 1'b0},
        {f_xo(5'd22, 5'd1, 5'd2, 1'b1, 9'd75, 1'b0),  64'h5,                64'h6,               1'b1, 1'b0, 1'b1},
        {f_x(5'd23, 5'd1, 5'd2, 10'd779, 1'b1),     64'h5,                64'h6,               1'b1, 1'b0, 1'b1},
        {f_xo(5'd24, 5'd1, 5'd2, 1'b0, 9'd266, 1'b0), 64'h5,                64'h6,               1'b1, 1'b0, 1'b1},
        {32'h38601234,                             64'h5,                64'h6,               1'b1, 1'b0, 1'b1}
    };

    // Reference model written from the requirements.
    task automatic model(input logic [31:0] w, input logic [63:0] ra, input logic [63:0] rb,
                         input logic m64, input logic sin,
                         output logic lg, output logic [63:0] d, output logic ovw,
                         output logic ov, output logic sow, output logic crw,
                         output logic [3:0] cr);
        logic [63:0] a, b, raw, msk, ras, raz, rah, rbs, rbz;
        logic sub, oe, rc, c, lt, eq;
        ras = {{32{ra[31]}}, ra[31:0]};
        raz = {32'd0, ra[31:0]};
        rah = {ra[31:0], 32'd0};
        rbs = {{32{rb[31]}}, rb[31:0]};
        rbz = {32'd0, rb[31:0]};
        lg = 1'b1; sub = 1'b0; oe = 1'b0; rc = 1'b0; a = '0; b = '0; msk = '0;
        if (w[31:26] == 6'd7) begin
            a = ra; b = {{48{w[15]}}, w[15:0]}; msk = 64'hef31a883837039a0;
        end else if (w[31:26] == 6'd31 && !w[0] && w[10:1] == 10'd779) begin
            a = ras; b = rbs; sub = 1'b1; msk = 64'h5ba1758b11ae4e43;
        end else if (w[31:26] == 6'd31 && !w[0] && w[10:1] == 10'd267) begin
            a = raz; b = rbz; sub = 1'b1; msk = 64'h1feb9d95f9f0cea5;
        end else if (w[31:26] == 6'd31) begin
            oe = w[10]; rc = w[0];
            case (w[9:1])
                9'd235: begin a = ras; b = rbs; msk = oe ? 64'h37291ea821fbaf9d : 64'h4931591f31f56de1; end
                9'd75:  begin lg = !oe; a = ras; b = rbs; msk = 64'h3426dcf55920989c; end
                9'd11:  begin lg = !oe; a = raz; b = rbz; msk = 64'h491edb8a5f695d49; end
                9'd491: begin sub = 1'b1; a = ras; b = rbs; msk = oe ? 64'h7098f59fd4822d48 : 64'h75a5d4895a3e15ba; end
                9'd459: begin sub = 1'b1; a = raz; b = rbz; msk = oe ? 64'h6ec48c33b1fe6a8f : 64'h769c76af68d11402; end
                9'd427: begin sub = 1'b1; a = rah; b = rbs; msk = oe ? 64'h88ec39a41f3b07fd : 64'hdfd9d577965d84d2; end
                9'd395: begin sub = 1'b1; a = rah; b = rbz; msk = oe ? 64'h893cca367133b0d3 : 64'h8fc71f88b966fcf0; end
                default: lg = 1'b0;
            endcase
        end else begin
            lg = 1'b0;
        end
        raw = sub ? a - b : a + b;
        d   = raw ^ msk;
        c   = raw[32] ^ a[32] ^ b[32];
        ov  = (c ^ raw[31]) & ~(a[31] ^ b[31]);
        ovw = lg & oe;
        sow = ovw & ov;
        crw = lg & rc;
        lt  = m64 ? d[63] : d[31];
        eq  = m64 ? (d == 64'd0) : (d[31:0] == 32'd0);
        cr  = {lt, ~(lt | eq), eq, sow | sin};
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [63:0] ra, input logic [63:0] rb,
                         input logic m64, input logic sin, input logic [63:0] pc);
        insn = w; ra_val = ra; rb_val = rb; mode64 = m64; so_in = sin; cia = pc;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vec(input logic [31:0] w, input logic [63:0] ra, input logic [63:0] rb,
                           input logic m64, input logic sin, input logic [63:0] pc);
        logic lg, ovw, ov, sow, crw;
        logic [63:0] d, enia;
        logic [3:0] cr;
        model(w, ra, rb, m64, sin, lg, d, ovw, ov, sow, crw, cr);
        apply(w, ra, rb, m64, sin, pc);
        enia = m64 ? pc + 64'd4 : {32'd0, pc[31:0] + 32'd4};
        chk("R11", "out_valid", 64'(out_valid), 64'd1);
        chk("R1", "illegal", 64'(illegal), 64'(!lg));
        chk("R13", "rt_we", 64'(rt_we), 64'(lg));
        if (lg) begin
            chk("R13", "rt_idx", 64'(rt_idx), 64'(w[25:21]));
            chk("R4 R2 R3", "rt_data", rt_data, d);
        end
        chk(ovw ? "R5" : "R6", "ov_we", 64'(ov_we), 64'(ovw));
        chk(ovw ? "R5" : "R6", "so_we", 64'(so_we), 64'(sow));
        if (ovw) begin
            chk("R5", "ov_val", 64'(ov_val), 64'(ov));
            chk("R5", "ov32_val", 64'(ov32_val), 64'(ov));
        end
        chk("R7", "cr0_we", 64'(cr0_we), 64'(crw));
        if (crw) chk("R7 R8 R9", "cr0_val", 64'(cr0_val), 64'(cr));
        chk("R10", "nia", nia, enia);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        rst = 1'b1; in_valid = 1'b1; insn = f_im(5'd1, 5'd1, 16'h1);
        ra_val = '0; rb_val = '0; cia = '0; mode64 = 1'b1; so_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset holds everything quiet even with a valid word present
        chk("R12", "out_valid", 64'(out_valid), 64'd0);
        chk("R12", "writes", 64'({rt_we, ov_we, so_we, cr0_we, illegal}), 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;

        // R11: idle input gives no result
        @(posedge clk);
        @(negedge clk);
        chk("R11", "idle out_valid", 64'(out_valid), 64'd0);
        chk("R11", "idle writes", 64'({rt_we, ov_we, so_we, cr0_we, illegal}), 64'd0);

        // Table walk, both modes via the vector bit
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i][162:131], VECS[i][130:67], VECS[i][66:3],
                    VECS[i][2], VECS[i][1], 64'h0000_0000_1000_0000 + 64'(i) * 64'd4);
            chk("R1", "table illegal", 64'(illegal), 64'(VECS[i][0]));
        end

        // Hand-computed corner cases
        apply(f_im(5'd1, 5'd2, 16'h0), 64'h0, 64'h0, 1'b1, 1'b0, 64'h100);
        chk("R4", "mulimm zero operands", rt_data, 64'hef31a883837039a0);

        apply(f_x(5'd3, 5'd1, 5'd2, 10'd267, 1'b0), 64'h5, 64'h5, 1'b1, 1'b0, 64'h104);
        chk("R4", "modu equal operands", rt_data, 64'h1feb9d95f9f0cea5);

        apply(f_xo(5'd9, 5'd1, 5'd2, 1'b1, 9'd235, 1'b1), 64'h7fffffff, 64'h1, 1'b1, 1'b0, 64'h108);
        chk("R5", "mullo ovf ov_val", 64'(ov_val), 64'd1);
        chk("R5", "mullo ovf so_we", 64'(so_we), 64'd1);
        chk("R8", "cr0 takes new SO", 64'(cr0_val), 64'b0101);

        apply(f_xo(5'd9, 5'd1, 5'd2, 1'b0, 9'd75, 1'b0), 64'h7fffffff, 64'h1, 1'b1, 1'b0, 64'h10c);
        chk("R6", "mulhi no ov write", 64'({ov_we, so_we}), 64'd0);

        apply(f_xo(5'd7, 5'd8, 5'd9, 1'b0, 9'd235, 1'b1), 64'h31f56de1, 64'h0, 1'b0, 1'b1, 64'h110);
        chk("R9", "low-word zero EQ in 32-bit mode", 64'(cr0_val), 64'b0011);
        apply(f_xo(5'd7, 5'd8, 5'd9, 1'b0, 9'd235, 1'b1), 64'h31f56de1, 64'h0, 1'b1, 1'b1, 64'h114);
        chk("R9", "same word GT in 64-bit mode", 64'(cr0_val), 64'b0101);

        apply(f_xo(5'd9, 5'd1, 5'd2, 1'b0, 9'd266, 1'b1), 64'h1, 64'h1, 1'b1, 1'b0, 64'h118);
        chk("R1", "unknown word mutes writes", 64'({rt_we, ov_we, so_we, cr0_we}), 64'd0);

        apply(f_im(5'd1, 5'd2, 16'h1), 64'h1, 64'h0, 1'b0, 1'b0, 64'h0000_0001_ffff_fffc);
        chk("R10", "nia wraps in 32-bit mode", nia, 64'h0);
        apply(f_im(5'd1, 5'd2, 16'h1), 64'h1, 64'h0, 1'b1, 1'b0, 64'h0000_0001_ffff_fffc);
        chk("R10", "nia carries in 64-bit mode", nia, 64'h0000_0002_0000_0000);

        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R11", "drop to idle", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule